// File: doc/BRIEF.md
# Power management event control register

A single 32-bit control and status word that collects wake-up events from two PHY energy detectors and one wake-on-LAN detector. Each source has a sticky status flag and an enable. The block turns enabled, pending events into a power-management interrupt request and, through a global gate, into a request for the external PME output stage. The polarity and pulse shaping of that output stage are handled elsewhere.

The same word holds a self-clearing reset request for an internal virtual PHY. It also reports the device-ready input, so software can poll this register while the device is still coming out of reset.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset every stored field reads 0. The read value at the register address is then just the ready mirror (bit 0), and both request outputs are low.
- R2: Reserved bits (all bits except 0, 1, 5, 9, 10, 14, 15, 16, 17) always read 0 and ignore writes. Writing all ones reads back 0x0000C603 when the device is ready.
- R3: A status flag sets on the rising edge of its event input. Bit 16 is energy detect for port 1, bit 17 for port 2, and bit 5 is wake-on-LAN.
- R4: Writing 1 to a status bit clears it only while that source's event input is low. If the input is still high, the bit stays set. Writing 0 has no effect.
- R5: The enables are read/write and reset to 0: bit 14 for port 1, bit 15 for port 2, bit 9 for wake-on-LAN, and bit 1 for the global PME enable.
- R6: `pme_irq_o` is the OR over all sources of (status AND enable), independent of the global PME enable.
- R7: `pme_req_o` equals `pme_irq_o` AND the global PME enable.
- R8: Writing 1 to bit 10 sets the virtual PHY reset and drives `vphy_rst_o`. The bit clears in the cycle after `vphy_rst_done_i` is seen high while it is set.
- R9: While bit 10 reads 1, every write to it, of 0 or 1, is ignored.
- R10: Bit 0 mirrors `dev_ready_i`. The register reads and writes normally whatever the ready level.
- R11: A write to any address other than 0x084 changes nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 12 | Byte address of the access |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| ed_evt_i | input | 2 | Energy-detect event per port (bit 0 = port 1) |
| wol_evt_i | input | 1 | Wake-on-LAN event |
| vphy_rst_done_i | input | 1 | Virtual PHY has left reset |
| dev_ready_i | input | 1 | Device ready level |
| vphy_rst_o | output | 1 | Virtual PHY reset request |
| pme_irq_o | output | 1 | PME interrupt request |
| pme_req_o | output | 1 | Gated request to the PME output stage |

## Verification
The assertions assume the event inputs and `vphy_rst_done_i` are synchronous to `clk_i`. They also assume the done input is only meaningful while a reset request is pending. The stimulus changes every input at the falling edge and samples half a cycle later. Events are applied as one-cycle pulses for the enable sweeps. A held level is used only where the test must show that a clear is blocked, and the done pulse is given only after a reset request has been written.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W        = 32;
  localparam int N_ED         = 2;
  localparam int N_SRC        = N_ED + 1;
  localparam int B_READY      = 0;
  localparam int B_PME_EN     = 1;
  localparam int B_WOL_STS    = 5;
  localparam int B_WOL_EN     = 9;
  localparam int B_VPHY_RST   = 10;
  localparam int B_ED_EN_LSB  = 14;
  localparam int B_ED_STS_LSB = 16;
endpackage

// File: rtl/pm_evt_sticky.sv
module pm_evt_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic sts_o
);
  logic evt_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      evt_q <= evt_i;
      // clear only honoured once the source has dropped
      sts_q <= (sts_q & ~(clr_i & ~evt_i)) | (evt_i & ~evt_q);
    end
  end

  assign sts_o = sts_q;

  p_set_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !evt_q) |=> sts_o);
  p_hold_while_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o && evt_i) |=> sts_o);
  p_no_clear_without_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o && !clr_i) |=> sts_o);
endmodule

// File: rtl/pm_vphy_rst.sv
module pm_vphy_rst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  output logic rst_o
);
  logic rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rst_q <= 1'b0;
    else if (rst_q)  rst_q <= ~done_i;   // writes locked out while pending
    else if (set_i)  rst_q <= 1'b1;
  end

  assign rst_o = rst_q;

  p_lock_while_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && !done_i) |=> rst_o);
  p_clear_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && done_i) |=> !rst_o);
  p_start_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_o && set_i) |=> rst_o);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h084
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [N_ED-1:0]   ed_evt_i,
  input  logic              wol_evt_i,
  input  logic              vphy_rst_done_i,
  input  logic              dev_ready_i,
  output logic              vphy_rst_o,
  output logic              pme_irq_o,
  output logic              pme_req_o
);
  logic             sel, wr;
  logic [N_ED-1:0]  ed_en_q;
  logic             wol_en_q, pme_en_q;
  logic [N_SRC-1:0] src_evt, src_clr, src_sts, src_en;
  logic             vphy_q;

  assign sel = (reg_addr_i == REG_ADDR);
  assign wr  = sel & reg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ed_en_q  <= '0;
      wol_en_q <= 1'b0;
      pme_en_q <= 1'b0;
    end else if (wr) begin
      ed_en_q  <= reg_wdata_i[B_ED_EN_LSB +: N_ED];
      wol_en_q <= reg_wdata_i[B_WOL_EN];
      pme_en_q <= reg_wdata_i[B_PME_EN];
    end
  end

  assign src_evt = {wol_evt_i, ed_evt_i};
  assign src_en  = {wol_en_q, ed_en_q};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int STS_BIT = (i < N_ED) ? (B_ED_STS_LSB + i) : B_WOL_STS;
    assign src_clr[i] = wr & reg_wdata_i[STS_BIT];
    pm_evt_sticky u_sticky (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (src_evt[i]),
      .clr_i (src_clr[i]),
      .sts_o (src_sts[i])
    );
  end

  pm_vphy_rst u_vphy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wr & reg_wdata_i[B_VPHY_RST]),
    .done_i(vphy_rst_done_i),
    .rst_o (vphy_q)
  );

  assign vphy_rst_o = vphy_q;
  assign pme_irq_o  = |(src_sts & src_en);
  assign pme_req_o  = pme_irq_o & pme_en_q;

  always_comb begin
    reg_rdata_o = '0;
    if (sel) begin
      reg_rdata_o[B_READY]                  = dev_ready_i;
      reg_rdata_o[B_PME_EN]                 = pme_en_q;
      reg_rdata_o[B_WOL_STS]                = src_sts[N_ED];
      reg_rdata_o[B_WOL_EN]                 = wol_en_q;
      reg_rdata_o[B_VPHY_RST]               = vphy_q;
      reg_rdata_o[B_ED_EN_LSB +: N_ED]      = ed_en_q;
      reg_rdata_o[B_ED_STS_LSB +: N_ED]     = src_sts[N_ED-1:0];
    end
  end

  p_req_needs_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_req_o |-> pme_irq_o);
  p_irq_needs_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_irq_o |-> (src_sts != '0));
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & 32'hFFFC_39DC) == '0);
  p_enable_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable({ed_en_q, wol_en_q, pme_en_q}));
endmodule

// File: tb/pm_event_ctrl_bench.sv
module pm_event_ctrl_bench;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_ni = 0;
  logic [11:0] addr = 12'h084;
  logic        we = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0]  ed = 0;
  logic        wol = 0, done = 0, ready = 0;
  logic        vphy, irq, req;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  pm_event_ctrl u_pm_event_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ed_evt_i(ed), .wol_evt_i(wol),
    .vphy_rst_done_i(done), .dev_ready_i(ready), .vphy_rst_o(vphy),
    .pme_irq_o(irq), .pme_req_o(req)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0; addr = 12'h084;
  endtask

  task automatic pulse(input logic [2:0] p);
    @(negedge clk); ed = p[1:0]; wol = p[2];
    @(negedge clk); ed = 0; wol = 0;
  endtask

  function automatic logic [31:0] img(input logic rdy, input logic pme,
                                      input logic [2:0] en, input logic [2:0] st, input logic vr);
    return 32'(rdy) | (32'(pme) << 1) | (32'(st[2]) << 5) | (32'(en[2]) << 9)
         | (32'(vr) << 10) | (32'(en[1:0]) << 14) | (32'(st[1:0]) << 16);
  endfunction

  initial begin
    #(CLK_NS*150000);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] e;
    #(CLK_NS*3);
    chk(rdata == 0, "R1", rdata, 0);
    chk({vphy, irq, req} == 0, "R1 outs", {vphy, irq, req}, 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk); #1;
    chk(rdata == 0, "R1 after release", rdata, 0);
    // R10: accessible while not ready
    wr(12'h084, 32'h2);
    #1 chk(rdata == 32'h2, "R10 rw not ready", rdata, 32'h2);
    ready = 1; #1;
    chk(rdata == 32'h3, "R10 mirror", rdata, 32'h3);
    // R2 / R5 / R8
    wr(12'h084, 32'hFFFF_FFFF);
    #1 chk(rdata == 32'h0000_C603, "R2 R5", rdata, 32'h0000_C603);
    chk(vphy == 1, "R8 set", vphy, 1);
    wr(12'h084, 32'h0000_C203);
    #1 chk(vphy == 1, "R9 write0 ignored", vphy, 1);
    chk(rdata == 32'h0000_C603, "R9 readback", rdata, 32'h0000_C603);
    repeat (3) @(negedge clk);
    #1 chk(vphy == 1, "R8 holds until done", vphy, 1);
    @(negedge clk); done = 1;
    @(negedge clk); done = 0; #1;
    chk(vphy == 0, "R8 cleared", vphy, 0);
    chk(rdata == 32'h0000_C203, "R8 readback", rdata, 32'h0000_C203);
    // R11
    wr(12'h080, 32'h0000_0000);
    #1 chk(rdata == 32'h0000_C203, "R11 other addr", rdata, 32'h0000_C203);
    @(negedge clk); addr = 12'h088; #1;
    chk(rdata == 0, "R11 read elsewhere", rdata, 0);
    addr = 12'h084;
    wr(12'h084, 32'h0);
    // sweep: enables x global enable x event pattern
    for (int m = 0; m < 8; m++)
      for (int g = 0; g < 2; g++)
        for (int p = 1; p < 8; p++) begin
          logic ei;
          wr(12'h084, img(0, g[0], m[2:0], 3'b0, 0));
          pulse(p[2:0]);
          #1;
          ei = |(m[2:0] & p[2:0]);
          e  = img(1, g[0], m[2:0], p[2:0], 0);
          chk(rdata == e, "R3 status", rdata, e);
          chk(irq == ei, "R6 irq", irq, ei);
          chk(req == (ei & g[0]), "R7 req", req, ei & g[0]);
          wr(12'h084, 32'h0003_0020);
          #1 chk(rdata == 32'h1, "R4 clear", rdata, 32'h1);
        end
    // R4: clear blocked while event held
    @(negedge clk); ed = 2'b01; wol = 1;
    wr(12'h084, 32'h0003_0020);
    #1 chk(rdata == 32'h0001_0021, "R4 held", rdata, 32'h0001_0021);
    wr(12'h084, 32'h0);
    #1 chk(rdata == 32'h0001_0021, "R4 write0", rdata, 32'h0001_0021);
    @(negedge clk); ed = 0; wol = 0;
    wr(12'h084, 32'h0001_0000);
    #1 chk(rdata == 32'h21, "R4 partial clear", rdata, 32'h21);
    wr(12'h084, 32'h20);
    #1 chk(rdata == 32'h1, "R4 final clear", rdata, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule